// File: doc/BRIEF.md
# Self-timed precharge/evaluate pipeline controller

This block is a clocked model of a chain of dynamic logic levels that run as an asynchronous micropipeline. Each level alternates between a precharge phase and an evaluate phase. Its phase signal is high while it evaluates or holds a result, and low while it precharges or sits precharged. Its completion flag rises when an evaluation ends and falls when a precharge ends. A level leaves the precharged state only on a rising edge from its predecessor's completion flag. It begins precharging only on a rising edge of its successor's phase signal, which marks that the successor has latched the result. Because each phase change follows one of two separate edge rules, one level can refill while the next is still working, and results stream through at a fixed rate set by the slowest handshake loop.

The producer places a word on `in_data` and raises `in_valid`. It keeps the word until `in_ack` shows that level 0 has latched it, then lowers `in_valid` again before it offers the next word. The consumer sees `out_valid` and reads `out_data`. It then raises `out_ack`, and the last level precharges. If the consumer withholds the acknowledge, the whole chain stalls with every word kept. Levels flagged in `DELAY_MASK` are delay latches: they carry a signal across a skipped level unchanged but still take part in the handshake. All other levels apply a fixed stand-in function. Evaluate and precharge times are the parameters `EVAL_CYC` and `PCHG_CYC`.

Top module: `mp_ctrl`

## Requirements
- R1: While reset is held and after it is released with no stimulus, `in_ack`, `out_valid`, every bit of `lvl_intclk` and every bit of `lvl_done` are 0, so every level is precharged.
- R2: Level 0 latches `in_data` only after a rising edge of `in_valid` while it is precharged. `in_ack` is high for exactly one cycle, the cycle at whose closing clock edge the word is captured. With an idle level 0, that cycle is the one after the cycle in which `in_valid` rises.
- R3: With an empty chain, `out_valid` first goes high NLVL*(EVAL_CYC+2) clock cycles after the cycle in which `in_valid` rises (32 cycles at the defaults).
- R4: A logic level at 0-based index i maps its latched 16-bit word x to rotate-left(x,3) XOR (0x5A5A XOR four copies of the 4-bit value i). A level whose bit is set in `DELAY_MASK` passes x unchanged (default mask 0b0100, so level 2 is a delay level). `out_data` is bits 13..0 of the last level's word.
- R5: Words leave in the order they entered, with none lost or duplicated, under any consumer stall. While `out_valid` is high and no rising `out_ack` edge has come, `out_valid` stays high and `out_data` stays constant.
- R6: When `out_ack` rises during a cycle in which `out_valid` is high, `out_valid` is low in the next cycle.
- R7: With a producer that is never late and a consumer that acknowledges at once, successive results appear every EVAL_CYC+PCHG_CYC+6 cycles (15 at the defaults).
- R8: No two adjacent levels are evaluating at the same time. Evaluating means phase high and completion low. This holds whenever EVAL_CYC <= PCHG_CYC+4.
- R9: A level's completion rises exactly EVAL_CYC cycles after its phase signal rises. It falls exactly PCHG_CYC cycles after its phase signal falls. The phase signal rises only while completion is low.
- R10: Holding `out_ack` high has no effect beyond its rising edge. A later result stays valid and unchanged until `out_ack` falls and rises again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Producer strobe; a rising edge offers `in_data` |
| in_data | input | IN_W | Primary data word |
| in_ack | output | 1 | Level 0 is capturing `in_data` at the end of this cycle |
| out_valid | output | 1 | Last level holds a finished result |
| out_data | output | OUT_W | Result word from the last level |
| out_ack | input | 1 | Consumer acknowledge; its rising edge starts the last level's precharge |
| lvl_intclk | output | NLVL | Phase signal of each level (1 = evaluate or hold) |
| lvl_done | output | NLVL | Completion flag of each level |

## Verification
`in_ack` is due one cycle after the cycle in which `in_valid` rises. The first result is due NLVL*(EVAL_CYC+2) cycles after that rise, and in a free-running stream each further result follows EVAL_CYC+PCHG_CYC+6 cycles later. `out_valid` drops one cycle after an acknowledge edge. Each level's completion follows its phase edges by EVAL_CYC cycles on a rise and PCHG_CYC cycles on a fall. The bench drives inputs and samples outputs on the falling clock edge, and it counts rising edges from the stimulus. Each value is compared in exactly the cycle the count predicts, so a result that comes one cycle early or late fails.

// File: rtl/mp_pkg.sv
package mp_pkg;
  typedef enum logic [2:0] {
    PH_PRE,
    PH_HSE,
    PH_EVAL,
    PH_DONE,
    PH_HSP,
    PH_PCHG
  } phase_e;

  localparam int unsigned ROT_AMT = 3;
  localparam logic [15:0] KEY_BASE = 16'h5A5A;
endpackage

// File: rtl/mp_token.sv
module mp_token (
  input  logic clk,
  input  logic rst_n,
  input  logic sig_i,
  input  logic take_i,
  output logic tok_o
);
  logic prev_q;
  logic held_q;
  logic rise;

  assign rise  = sig_i & ~prev_q;
  assign tok_o = held_q | rise;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      held_q <= 1'b0;
    end else begin
      prev_q <= sig_i;
      held_q <= take_i ? 1'b0 : tok_o;
    end
  end

  // R5: a second edge never lands on a pending one, so no word is overwritten
  p_no_overrun_r5: assert property (@(posedge clk) disable iff (!rst_n)
    held_q |-> !rise);
endmodule

// File: rtl/mp_level.sv
module mp_level
  import mp_pkg::*;
#(
  parameter int unsigned W        = 16,
  parameter int unsigned EVAL_CYC = 6,
  parameter int unsigned PCHG_CYC = 3,
  parameter int unsigned IDX      = 0,
  parameter bit          PASS     = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         p2_i,
  input  logic         p1_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o,
  output logic         intclk_o,
  output logic         done_o,
  output logic         hold_o,
  output logic         latch_o
);
  localparam int unsigned MAXC = (EVAL_CYC > PCHG_CYC) ? EVAL_CYC : PCHG_CYC;
  localparam int unsigned CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] E_LD = CW'(EVAL_CYC - 1);
  localparam logic [CW-1:0] P_LD = CW'(PCHG_CYC - 1);
  localparam logic [3:0]    TAG  = 4'(IDX);
  localparam logic [W-1:0]  KEY  = W'(KEY_BASE ^ {4{TAG}});

  function automatic logic [W-1:0] stage_out(input logic [W-1:0] x);
    logic [W-1:0] r;
    r = (x << ROT_AMT) | (x >> (W - ROT_AMT));
    if (PASS) return x;
    return r ^ KEY;
  endfunction

  phase_e        st_q, st_d;
  logic [CW-1:0] cnt_q;
  logic          go_tok;
  logic          rel_tok;
  logic          at_pre;
  logic          at_done;

  assign at_pre  = (st_q == PH_PRE);
  assign at_done = (st_q == PH_DONE);

  mp_token u_go (
    .clk    (clk),
    .rst_n  (rst_n),
    .sig_i  (p2_i),
    .take_i (at_pre),
    .tok_o  (go_tok)
  );

  mp_token u_rel (
    .clk    (clk),
    .rst_n  (rst_n),
    .sig_i  (p1_i),
    .take_i (at_done),
    .tok_o  (rel_tok)
  );

  always_comb begin
    st_d = st_q;
    case (st_q)
      PH_PRE:  if (go_tok) st_d = PH_HSE;
      PH_HSE:  st_d = PH_EVAL;
      PH_EVAL: if (cnt_q == '0) st_d = PH_DONE;
      PH_DONE: if (rel_tok) st_d = PH_HSP;
      PH_HSP:  st_d = PH_PCHG;
      PH_PCHG: if (cnt_q == '0) st_d = PH_PRE;
      default: st_d = PH_PRE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= PH_PRE;
      cnt_q <= '0;
      q_o   <= '0;
    end else begin
      st_q <= st_d;
      if (st_q == PH_HSE)      cnt_q <= E_LD;
      else if (st_q == PH_HSP) cnt_q <= P_LD;
      else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
      if (st_q == PH_HSE) q_o <= stage_out(d_i);
    end
  end

  assign intclk_o = (st_q == PH_EVAL) | (st_q == PH_DONE) | (st_q == PH_HSP);
  assign done_o   = (st_q == PH_DONE) | (st_q == PH_HSP) | (st_q == PH_PCHG);
  assign hold_o   = at_done;
  assign latch_o  = (st_q == PH_HSE);

  // R9: evaluation starts only from the precharged state
  p_eval_from_pre_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(intclk_o) |-> !$past(done_o));

  // R9: completion rises only at the end of an evaluation
  p_done_after_eval_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> (intclk_o && $past(intclk_o)));

  // R5: the latched word changes only when a new evaluation begins
  p_latch_on_eval_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(q_o) |-> $rose(intclk_o));
endmodule

// File: rtl/mp_ctrl.sv
module mp_ctrl
  import mp_pkg::*;
#(
  parameter int unsigned IN_W       = 16,
  parameter int unsigned OUT_W      = 14,
  parameter int unsigned NLVL       = 4,
  parameter int unsigned EVAL_CYC   = 6,
  parameter int unsigned PCHG_CYC   = 3,
  parameter int unsigned DELAY_MASK = 32'h4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [IN_W-1:0]  in_data,
  output logic             in_ack,
  output logic             out_valid,
  output logic [OUT_W-1:0] out_data,
  input  logic             out_ack,
  output logic [NLVL-1:0]  lvl_intclk,
  output logic [NLVL-1:0]  lvl_done
);
  localparam int unsigned LAST = NLVL - 1;

  logic [IN_W-1:0] q_w [NLVL];
  logic [NLVL-1:0] hold_w;
  logic [NLVL-1:0] latch_w;
  logic [NLVL-1:0] eval_w;

  for (genvar k = 0; k < NLVL; k++) begin : g_lvl
    logic            p2_s;
    logic            p1_s;
    logic [IN_W-1:0] d_s;

    if (k == 0) begin : g_head
      assign p2_s = in_valid;
      assign d_s  = in_data;
    end else begin : g_body
      assign p2_s = lvl_done[k-1];
      assign d_s  = q_w[k-1];
    end

    if (k == LAST) begin : g_tail
      assign p1_s = out_ack;
    end else begin : g_mid
      assign p1_s = lvl_intclk[k+1];
    end

    mp_level #(
      .W        (IN_W),
      .EVAL_CYC (EVAL_CYC),
      .PCHG_CYC (PCHG_CYC),
      .IDX      (k),
      .PASS     (((DELAY_MASK >> k) & 1) != 0)
    ) u_level (
      .clk      (clk),
      .rst_n    (rst_n),
      .p2_i     (p2_s),
      .p1_i     (p1_s),
      .d_i      (d_s),
      .q_o      (q_w[k]),
      .intclk_o (lvl_intclk[k]),
      .done_o   (lvl_done[k]),
      .hold_o   (hold_w[k]),
      .latch_o  (latch_w[k])
    );

    assign eval_w[k] = lvl_intclk[k] & ~lvl_done[k];
  end

  for (genvar k = 0; k < LAST; k++) begin : g_pair
    // R8: neighbouring levels never evaluate together
    p_no_adjacent_eval_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !(eval_w[k] && eval_w[k+1]));

    // R5: a level captures only while its predecessor holds a finished word
    p_latch_needs_data_r5: assert property (@(posedge clk) disable iff (!rst_n)
      latch_w[k+1] |-> hold_w[k]);

    // R5: a level gives up its word only after the next level has latched it
    p_release_after_latch_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(hold_w[k]) |-> $past(lvl_intclk[k+1]));
  end

  assign in_ack    = latch_w[0];
  assign out_valid = hold_w[LAST];
  assign out_data  = q_w[LAST][OUT_W-1:0];

  // R5: the result is held, unchanged, until the consumer acknowledges
  p_out_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !(out_ack && !$past(out_ack))) |=> (out_valid && $stable(q_w[LAST])));

  // R6: an acknowledge edge during a valid result clears it next cycle
  p_ack_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ack && !$past(out_ack)) |=> !out_valid);

  // R2: the capture strobe never lasts two cycles
  p_ack_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_ack |=> !in_ack);
endmodule

// File: tb/mp_ctrl_test.sv
`timescale 1ns/1ps
module mp_ctrl_test;
  localparam int E  = 6;
  localparam int P  = 3;
  localparam int N  = 4;
  localparam int PERIOD = E + P + 6;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [15:0] in_data;
  logic        in_ack;
  logic        out_valid;
  logic [13:0] out_data;
  logic        out_ack;
  logic [N-1:0] lvl_intclk;
  logic [N-1:0] lvl_done;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  logic [15:0] wq [32];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  mp_ctrl uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_ack(in_ack), .out_valid(out_valid), .out_data(out_data),
    .out_ack(out_ack), .lvl_intclk(lvl_intclk), .lvl_done(lvl_done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic logic [13:0] model(input logic [15:0] w);
    logic [15:0] v;
    v = w;
    for (int lv = 0; lv < N; lv++) begin
      logic [3:0] t;
      t = lv[3:0];
      if (lv != 2) v = {v[12:0], v[15:13]} ^ {t ^ 4'h5, t ^ 4'hA, t ^ 4'h5, t ^ 4'hA};
    end
    return v[13:0];
  endfunction

  // R8 and R9 monitors
  int rise_at = 0;
  int fall_at = 0;
  logic ic0_q = 1'b0;
  logic dn0_q = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      for (int k = 0; k < N - 1; k++) begin
        if (lvl_intclk[k] && !lvl_done[k] && lvl_intclk[k+1] && !lvl_done[k+1])
          chk(1'b0, "R8 adjacent eval", k, -1);
      end
      if (lvl_intclk[0] && !ic0_q) rise_at = cyc;
      if (!lvl_intclk[0] && ic0_q) fall_at = cyc;
      if (lvl_done[0] && !dn0_q) chk(cyc - rise_at == E, "R9 done rise", cyc - rise_at, E);
      if (!lvl_done[0] && dn0_q) chk(cyc - fall_at == P, "R9 done fall", cyc - fall_at, P);
      ic0_q = lvl_intclk[0];
      dn0_q = lvl_done[0];
    end
  end

  task automatic send(input logic [15:0] w);
    @(negedge clk);
    in_data  = w;
    in_valid = 1'b1;
    do @(negedge clk); while (!in_ack);
    @(negedge clk);
    chk(!in_ack, "R2 ack width", in_ack, 0);
    in_valid = 1'b0;
  endtask

  task automatic receive(input logic [13:0] exp, input int stall, output int seen);
    while (!out_valid) @(negedge clk);
    seen = cyc;
    chk(out_data == exp, "R4/R5 data", out_data, exp);
    for (int s = 0; s < stall; s++) begin
      @(negedge clk);
      chk(out_valid && out_data == exp, "R5 held", out_data, exp);
    end
    out_ack = 1'b1;
    @(negedge clk);
    chk(!out_valid, "R6 clear", out_valid, 0);
    out_ack = 1'b0;
  endtask

  task automatic t_reset();
    chk(!in_ack && !out_valid && lvl_intclk == '0 && lvl_done == '0, "R1 reset",
        {in_ack, out_valid, lvl_intclk, lvl_done}, 0);
  endtask

  task automatic t_single(input logic [15:0] w);
    int n = 0;
    int ackn = -10;
    @(negedge clk);
    in_data  = w;
    in_valid = 1'b1;
    do begin
      @(negedge clk);
      n++;
      if (n == ackn + 1) in_valid = 1'b0;
      if (in_ack) ackn = n;
    end while (!out_valid && n < 200);
    chk(ackn == 1, "R2 ack time", ackn, 1);
    chk(n == N * (E + 2), "R3 latency", n, N * (E + 2));
    chk(out_data == model(w), "R4 value", out_data, model(w));
    out_ack = 1'b1;
    @(negedge clk);
    chk(!out_valid, "R6 clear", out_valid, 0);
    out_ack = 1'b0;
    repeat (30) @(negedge clk);
    chk(lvl_intclk == '0 && lvl_done == '0, "R1 drained", {lvl_intclk, lvl_done}, 0);
  endtask

  task automatic t_stream(input int m, input bit stalls);
    logic [7:0] lf = 8'h5B;
    fork
      begin
        for (int i = 0; i < m; i++) send(wq[i]);
      end
      begin
        int prev = 0;
        int seen = 0;
        for (int i = 0; i < m; i++) begin
          int st;
          lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
          st = stalls ? int'(lf % 8'd23) : 0;
          @(negedge clk);
          receive(model(wq[i]), st, seen);
          if (!stalls && i > 0) chk(seen - prev == PERIOD, "R7 period", seen - prev, PERIOD);
          prev = seen;
        end
      end
    join
    repeat (5) @(negedge clk);
    chk(!out_valid, "R5 no duplicate", out_valid, 0);
  endtask

  task automatic t_held();
    fork
      begin
        send(16'hC0DE);
        send(16'h1357);
      end
      begin
        @(negedge clk);
        while (!out_valid) @(negedge clk);
        chk(out_data == model(16'hC0DE), "R4 first", out_data, model(16'hC0DE));
        out_ack = 1'b1;
        @(negedge clk);
        chk(!out_valid, "R6 clear", out_valid, 0);
        while (!out_valid) @(negedge clk);
        repeat (20) begin
          @(negedge clk);
          chk(out_valid && out_data == model(16'h1357), "R10 held ack", out_data,
              model(16'h1357));
        end
        out_ack = 1'b0;
        @(negedge clk);
        chk(out_valid, "R10 low ack", out_valid, 1);
        out_ack = 1'b1;
        @(negedge clk);
        chk(!out_valid, "R10 new edge", out_valid, 0);
        out_ack = 1'b0;
      end
    join
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog", cyc, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] g = 16'hACE1;
    for (int i = 0; i < 32; i++) begin
      g = {g[14:0], g[15] ^ g[13] ^ g[12] ^ g[10]};
      wq[i] = g;
    end
    rst_n    = 1'b0;
    in_valid = 1'b0;
    in_data  = '0;
    out_ack  = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_single(16'h0001);
    t_single(16'hFFFF);
    t_stream(12, 1'b0);
    t_stream(24, 1'b1);
    t_held();
    repeat (40) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule